// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Monitor

This block sits beside an I2C slave engine and measures how long the bus clock has been held low. SMBus sets a limit on that time. The block counts system clock cycles while every one of four conditions holds:

- the slave is enabled;
- SMBus-compatible operation is selected;
- the slave engine reports the bus as busy;
- the synchronised clock line is low.

If any of the four conditions drops, the count returns to zero at once.

When the count reaches the configured limit, a sticky timeout flag is raised. The limit defaults to 120000 cycles, which is 30 ms at a 4 MHz system clock. If interrupts are allowed, a single-cycle interrupt pulse is produced in the same cycle. Firmware reads the flag and runs its own recovery.

The flag stays set until firmware writes a clear strobe or the slave is disabled. Disabling the slave also stops the count, which fits the usual recovery step of toggling the enable to release the bus lines.

Top module: `smbus_lowclk_monitor`

## Requirements
- R1: After reset, `to_flag` and `to_irq` are 0.
- R2: With the slave enabled, SMBus mode on, the bus busy and `scl_sync` low on LIMIT consecutive rising clock edges, `to_flag` is 1 after the LIMIT-th edge and 0 after the (LIMIT-1)-th.
- R3: A cycle with `scl_sync` high clears the count, so a fresh run of LIMIT low cycles is needed before the flag sets.
- R4: While `bus_idle` is 1 the count does not advance and is cleared.
- R5: While `smb_mode` is 0 the count does not advance and is cleared.
- R6: While `slv_en` is 0 the count is cleared, and a set `to_flag` is cleared on the next edge.
- R7: The count saturates at LIMIT. A clock held low for longer than LIMIT cycles produces only one set event and one interrupt pulse.
- R8: When the flag sets with `irq_en` at 1 in that cycle, `to_irq` is 1 for exactly one cycle, aligned with the rising edge of `to_flag`.
- R9: When `irq_en` is 0 in the cycle the flag sets, `to_flag` still sets and `to_irq` stays 0.
- R10: `to_flag` stays at 1 until `flag_clr` is 1 on an edge, or `slv_en` is 0 on an edge. Either one clears it on that edge.
- R11: If `flag_clr` is 1 in the same cycle the limit is reached, the set wins and `to_flag` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_sync | input | 1 | Bus clock line, already synchronised to `clk` |
| slv_en | input | 1 | Slave interface enable |
| smb_mode | input | 1 | SMBus-compatible timeout checking enabled |
| bus_idle | input | 1 | Slave engine reports no bus traffic |
| irq_en | input | 1 | Allows the interrupt pulse on timeout |
| flag_clr | input | 1 | Clear strobe for the timeout flag |
| to_flag | output | 1 | Sticky timeout status |
| to_irq | output | 1 | One-cycle interrupt pulse on timeout |

## Verification
The hardest situation to reach is a clear strobe that lands in exactly the cycle the count reaches the limit. It can only be reached after LIMIT uninterrupted qualifying cycles, and the bench counts those cycles itself so that it can place the strobe there.

The bench builds the design with a small limit, so that saturation and long low periods fit in a short run. It then breaks long low periods with single disqualifying cycles of each kind. The reference model follows every edge, so an off-by-one in the restart or the threshold shows up at once.

// File: rtl/smbto_pkg.sv
// Shared helpers for the clock-low timeout monitor.
// Assumes: limits are positive integers.
package smbto_pkg;
    // Width needed to hold the values 0..lim.
    function automatic int cnt_bits(input int lim);
        return (lim < 2) ? 1 : $clog2(lim + 1);
    endfunction
endpackage

// File: rtl/smbto_qualify.sv
// Decides whether the low-time counter may run in this cycle.
// Assumes: every input is already synchronous to clk.
module smbto_qualify (
    input  logic scl_sync,
    input  logic slv_en,
    input  logic smb_mode,
    input  logic bus_idle,
    output logic run
);
    // All four gating conditions must hold for the count to advance.
    always_comb begin
        run = slv_en && smb_mode && !bus_idle && !scl_sync;
    end
endmodule

// File: rtl/smbto_counter.sv
// Counts consecutive qualified cycles, saturating at LIMIT.
// It reports 'hit' in the one cycle that takes the count onto LIMIT.
// Assumes: LIMIT >= 1.
module smbto_counter #(
    parameter int LIMIT = 120000,
    parameter int CW    = smbto_pkg::cnt_bits(LIMIT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [CW-1:0] cnt,
    output logic          hit
);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);
    localparam logic [CW-1:0] PRE_V = CW'(LIMIT - 1);

    // Detect the cycle in which the count will reach the limit.
    always_comb begin
        hit = run && (cnt == PRE_V);
    end

    // Advance while qualified, hold at the limit, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LIM_V) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/smbto_status.sv
// Holds the sticky timeout flag and produces the interrupt pulse.
// Assumes: 'hit' is high for at most one cycle per low period.
module smbto_status (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic slv_en,
    input  logic flag_clr,
    input  logic irq_en,
    output logic to_flag,
    output logic to_irq
);
    // Sticky flag: a set wins over a clear; clear on the strobe or on disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_flag <= 1'b0;
        end else if (hit) begin
            to_flag <= 1'b1;
        end else if (flag_clr || !slv_en) begin
            to_flag <= 1'b0;
        end
    end

    // Interrupt pulse, aligned with the edge that sets the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_irq <= 1'b0;
        end else begin
            to_irq <= hit && irq_en;
        end
    end
endmodule

// File: rtl/smbus_lowclk_monitor.sv
// Top of the SMBus clock-low timeout monitor.
// It times continuous low clock while the slave is busy in SMBus mode, and
// flags a timeout when the time reaches LIMIT cycles.
// Assumes: scl_sync is already synchronised; synchronous active-low reset.
module smbus_lowclk_monitor #(
    parameter int LIMIT = 120000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_sync,
    input  logic slv_en,
    input  logic smb_mode,
    input  logic bus_idle,
    input  logic irq_en,
    input  logic flag_clr,
    output logic to_flag,
    output logic to_irq
);
    localparam int CW = smbto_pkg::cnt_bits(LIMIT);

    logic          run;
    logic          hit;
    logic [CW-1:0] cnt;

    smbto_qualify u_qual (
        .scl_sync (scl_sync),
        .slv_en   (slv_en),
        .smb_mode (smb_mode),
        .bus_idle (bus_idle),
        .run      (run)
    );

    smbto_counter #(.LIMIT(LIMIT), .CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .cnt   (cnt),
        .hit   (hit)
    );

    smbto_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .slv_en   (slv_en),
        .flag_clr (flag_clr),
        .irq_en   (irq_en),
        .to_flag  (to_flag),
        .to_irq   (to_irq)
    );
endmodule

// File: rtl/smbto_checker.sv
// Assertion checker for the clock-low timeout monitor, bound to the top.
// Assumes: synchronous active-low reset.
module smbto_checker #(
    parameter int LIMIT = 120000,
    parameter int CW    = smbto_pkg::cnt_bits(LIMIT)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          slv_en,
    input logic          irq_en,
    input logic          flag_clr,
    input logic          run,
    input logic [CW-1:0] cnt,
    input logic          to_flag,
    input logic          to_irq
);
    AST_CLEAR_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0)); // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT)); // R7
    AST_SET_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_flag) |-> $past(run)); // R2
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !slv_en |=> !to_flag); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        to_irq |-> ($past(irq_en) && $rose(to_flag))); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (to_flag && slv_en && !flag_clr) |=> to_flag); // R10
endmodule

bind smbus_lowclk_monitor smbto_checker #(.LIMIT(LIMIT), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .slv_en   (slv_en),
    .irq_en   (irq_en),
    .flag_clr (flag_clr),
    .run      (run),
    .cnt      (cnt),
    .to_flag  (to_flag),
    .to_irq   (to_irq)
);

// File: tb/smbus_lowclk_monitor_test.sv
module smbus_lowclk_monitor_test;
    localparam int LIM = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_sync = 1'b1, slv_en = 1'b0, smb_mode = 1'b0, bus_idle = 1'b1;
    logic irq_en = 1'b0, flag_clr = 1'b0;
    logic to_flag, to_irq;

    int n_chk = 0, n_fail = 0;
    string phase = "R1";

    // Behavioural reference model.
    int  m_cnt = 0;
    bit  m_flag = 0, m_irq = 0;

    always #5 clk = ~clk;

    smbus_lowclk_monitor #(.LIMIT(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .scl_sync(scl_sync), .slv_en(slv_en),
        .smb_mode(smb_mode), .bus_idle(bus_idle), .irq_en(irq_en),
        .flag_clr(flag_clr), .to_flag(to_flag), .to_irq(to_irq));

    always @(posedge clk) begin
        bit qual, reach;
        if (!rst_n) begin
            m_cnt = 0; m_flag = 0; m_irq = 0;
        end else begin
            qual  = slv_en && smb_mode && !bus_idle && !scl_sync;
            reach = qual && (m_cnt + 1 == LIM);
            m_irq = reach && irq_en;
            if (reach) m_flag = 1;
            else if (flag_clr || !slv_en) m_flag = 0;
            if (!qual) m_cnt = 0;
            else if (m_cnt < LIM) m_cnt = m_cnt + 1;
        end
    end

    task automatic check(input string tag, input logic got, input logic exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Drive inputs, let one edge pass, then compare with the model.
    task automatic cyc(input logic s, input logic en, input logic md, input logic idl,
                       input logic ie, input logic clr);
        scl_sync = s; slv_en = en; smb_mode = md; bus_idle = idl;
        irq_en = ie; flag_clr = clr;
        @(negedge clk);
        check(phase, to_flag, m_flag, "to_flag vs model");
        check(phase, to_irq,  m_irq,  "to_irq vs model");
    endtask

    // Qualified low cycles, repeated n times.
    task automatic low(input int n, input logic ie);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, ie, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", to_flag, 1'b0, "flag in reset");
        check("R1", to_irq, 1'b0, "irq in reset");
        rst_n = 1'b1;
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);

        phase = "R2";
        low(LIM - 1, 1'b1);
        check("R2", to_flag, 1'b0, "flag after LIMIT-1 low cycles");
        phase = "R8";
        low(1, 1'b1);
        check("R2", to_flag, 1'b1, "flag after LIMIT low cycles");
        check("R8", to_irq, 1'b1, "irq pulse on set");
        phase = "R7";
        low(1, 1'b1);
        check("R8", to_irq, 1'b0, "irq lasts one cycle");
        low(3 * LIM, 1'b1);
        check("R7", to_flag, 1'b1, "flag held while saturated");

        phase = "R10";
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R10", to_flag, 1'b1, "flag sticky after clock release");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        check("R10", to_flag, 1'b0, "flag cleared by strobe");

        phase = "R3";
        low(LIM - 2, 1'b1);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        low(LIM - 1, 1'b1);
        check("R3", to_flag, 1'b0, "high cycle restarts count");
        low(1, 1'b1);
        check("R3", to_flag, 1'b1, "fresh full run sets flag");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);

        phase = "R4";
        low(LIM - 2, 1'b1);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        low(LIM - 1, 1'b1);
        check("R4", to_flag, 1'b0, "idle clears count");
        low(1, 1'b1);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);

        phase = "R5";
        low(LIM - 2, 1'b1);
        for (int i = 0; i < 2 * LIM; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R5", to_flag, 1'b0, "mode off blocks count");
        low(LIM - 1, 1'b1);
        check("R5", to_flag, 1'b0, "mode off cleared count");
        low(1, 1'b1);

        phase = "R6";
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R6", to_flag, 1'b0, "disable clears flag");
        for (int i = 0; i < 2 * LIM; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R6", to_flag, 1'b0, "disabled does not count");

        phase = "R9";
        low(LIM, 1'b0);
        check("R9", to_flag, 1'b1, "flag sets with irq off");
        check("R9", to_irq, 1'b0, "no irq with irq off");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);

        phase = "R11";
        low(LIM - 1, 1'b1);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        check("R11", to_flag, 1'b1, "set wins over clear");
        low(2, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule